// File: doc/BRIEF.md
# Low-Power Wakeup Pin Debouncer

This block filters two wakeup pins before they are allowed to pull the system out of a low-power state. It does not measure time in clock cycles. It counts rising edges of a slow timing tick that arrives from a real-time-clock output. A pin is accepted only after it has stayed active across the number of tick edges that a 3-bit period code selects. Code 0 switches the whole filter off.

Each pin has its own enable. When a pin qualifies, the block raises a one-cycle wake pulse on that pin's bit. If the clear-enable input is set, the same qualification also emits a one-cycle pulse that wipes the lower half of a bank of backup registers. The tick and both pins are asynchronous to the local clock, so they are synchronized inside the block. A qualified tick edge shows up on the outputs on the third clock edge after the tick input rises.

Top module: `lp_wake_debounce`

## Requirements
- R1: With period code k (1 to 7), an enabled pin that is held active (high) produces its wake pulse on the (k+1)-th tick rising edge counted while it stays active, and not earlier.
- R2: Period code 0 disables the filter: no wake pulse and no clear pulse are produced, whatever the pins and ticks do.
- R3: A pin whose enable bit is 0 (bit 0 of the enable input for pin 0, bit 1 for pin 1) never produces a wake pulse and never contributes to a clear pulse.
- R4: A wake pulse lasts one clock cycle on the bit of the qualifying pin (bit 0 for pin 0, bit 1 for pin 1). It fires once per active episode, and fires again only after the pin has gone inactive and qualified anew.
- R5: A pin that drops inactive, even briefly between ticks, loses its accumulated count and must requalify from zero.
- R6: Any change of the period code discards the counts of both pins, so that the new code's full tick count is needed afterwards.
- R7: When clear-enable is 1, each qualification cycle yields exactly one one-cycle clear pulse, also when both pins qualify in the same cycle. When clear-enable is 0, no clear pulse occurs.
- R8: After reset, both wake bits and the clear output are 0.
- R9: Only rising edges of the tick are counted. A tick held high for many clock cycles counts once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| period_code | input | 3 | Tick-count selector; 0 disables, k requires k+1 ticks |
| pin_en | input | 2 | Per-pin enable, bit i for pin i |
| clr_en | input | 1 | Allows a qualification to emit the backup clear pulse |
| wake_pin | input | 2 | Asynchronous active-high wakeup pins |
| tick_in | input | 1 | Asynchronous low-rate timing tick |
| wake_evt | output | 2 | One-cycle wake pulse per qualifying pin |
| bkp_clr | output | 1 | One-cycle clear pulse for the lower half of the backup registers |

## Verification
On every cycle the assertions check that wake and clear pulses last one cycle and appear only when the period code and the pin enables allowed them. They also check that a clear pulse follows clear-enable and always comes with a wake pulse. The exact tick count for each of the seven codes is shown only by the bench's scenarios, using a scoreboard that must contain an expected item before any pulse appears. The same holds for losing the count when a pin drops or the code changes, for counting a long tick once, and for rearming after the pin goes inactive.

// File: rtl/lp_wake_debounce.sv
module lp_wake_debounce #(
  parameter int NPIN   = 2,
  parameter int CODE_W = 3,
  parameter int SYNC   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] period_code,
  input  logic [NPIN-1:0]   pin_en,
  input  logic              clr_en,
  input  logic [NPIN-1:0]   wake_pin,
  input  logic              tick_in,
  output logic [NPIN-1:0]   wake_evt,
  output logic              bkp_clr
);
  localparam int CNT_W = CODE_W + 1;

  logic [SYNC-1:0]   tick_sh;
  logic              tick_d;
  logic [NPIN-1:0]   pin_sh [SYNC];
  logic [CODE_W-1:0] code_q;
  logic [NPIN-1:0]   qual;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_sh <= '0;
      tick_d  <= 1'b0;
      code_q  <= '0;
      for (int k = 0; k < SYNC; k++) pin_sh[k] <= '0;
    end else begin
      tick_sh   <= {tick_sh[SYNC-2:0], tick_in};
      tick_d    <= tick_sh[SYNC-1];
      code_q    <= period_code;
      pin_sh[0] <= wake_pin;
      for (int k = 1; k < SYNC; k++) pin_sh[k] <= pin_sh[k-1];
    end
  end

  wire              tick_rise = tick_sh[SYNC-1] & ~tick_d;
  wire              off       = (period_code == '0);
  wire              code_chg  = (period_code != code_q);
  wire [CNT_W-1:0]  target    = CNT_W'(period_code) + 1'b1;

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    logic [CNT_W-1:0] cnt;
    logic             done;
    wire              live = pin_en[i] & pin_sh[SYNC-1][i] & ~off;
    wire              step = live & ~code_chg & tick_rise & ~done;

    assign qual[i] = step & ((cnt + 1'b1) == target);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt  <= '0;
        done <= 1'b0;
      end else if (!live) begin
        cnt  <= '0;
        done <= 1'b0;
      end else if (code_chg) begin
        cnt  <= '0;
      end else if (step) begin
        cnt  <= cnt + 1'b1;
        done <= qual[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_evt <= '0;
      bkp_clr  <= 1'b0;
    end else begin
      wake_evt <= qual;
      bkp_clr  <= clr_en & |qual;
    end
  end

  // R2
  evt_needs_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_evt != '0) |-> ($past(period_code) != '0));
  // R3
  evt_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((wake_evt & ~$past(pin_en)) == '0));
  // R4
  evt_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((wake_evt & $past(wake_evt)) == '0));
  // R7
  clr_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bkp_clr |=> !bkp_clr);
  // R7
  clr_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bkp_clr |-> ($past(clr_en) && (wake_evt != '0)));
endmodule

// File: tb/sim_lp_wake_debounce.sv
module sim_lp_wake_debounce;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] period_code = '0;
  logic [1:0] pin_en = '0;
  logic       clr_en = 1'b0;
  logic [1:0] wake_pin = '0;
  logic       tick_in = 1'b0;
  logic [1:0] wake_evt;
  logic       bkp_clr;

  typedef struct { logic [2:0] v; string req; } exp_t;
  exp_t  q[$];
  string cur_req = "R8";
  int    checks = 0;
  int    fails = 0;
  bit    finished = 0;

  always #4 clk = ~clk;

  lp_wake_debounce u0 (
    .clk(clk), .rst_n(rst_n), .period_code(period_code), .pin_en(pin_en),
    .clr_en(clr_en), .wake_pin(wake_pin), .tick_in(tick_in),
    .wake_evt(wake_evt), .bkp_clr(bkp_clr));

  // monitor: every pulse must match the head of the scoreboard
  always @(negedge clk) begin
    if (rst_n && (wake_evt != 2'b00 || bkp_clr)) begin
      checks++;
      if (q.size() == 0) begin
        fails++;
        $display("FAIL %s: unexpected pulse clr/evt actual=%b expected=none", cur_req, {bkp_clr, wake_evt});
      end else begin
        exp_t e;
        e = q.pop_front();
        if ({bkp_clr, wake_evt} !== e.v) begin
          fails++;
          $display("FAIL %s: clr/evt actual=%b expected=%b", e.req, {bkp_clr, wake_evt}, e.v);
        end
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n, input int hi = 6);
    for (int t = 0; t < n; t++) begin
      tick_in = 1'b1; idle(hi);
      tick_in = 1'b0; idle(6);
    end
  endtask

  task automatic expect_item(input logic [2:0] v, input string req);
    exp_t e;
    e.v = v; e.req = req;
    q.push_back(e);
  endtask

  task automatic drained(input string req);
    idle(6);
    checks++;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL %s: pending expected items actual=%0d expected=0", req, q.size());
      q.delete();
    end
  endtask

  task automatic pins(input logic [1:0] p);
    wake_pin = p; idle(6);
  endtask

  initial begin
    idle(3);
    checks++;
    if (wake_evt !== 2'b00 || bkp_clr !== 1'b0) begin
      fails++;
      $display("FAIL R8: reset outputs actual=%b expected=000", {bkp_clr, wake_evt});
    end
    rst_n = 1'b1;
    idle(3);
    checks++;
    if (wake_evt !== 2'b00 || bkp_clr !== 1'b0) begin
      fails++;
      $display("FAIL R8: post-reset outputs actual=%b expected=000", {bkp_clr, wake_evt});
    end

    // R2: code 0 disables
    cur_req = "R2";
    pin_en = 2'b11; clr_en = 1'b1; pins(2'b11);
    ticks(10);
    drained("R2");
    pins(2'b00);

    // R3: disabled pins ignored
    cur_req = "R3";
    period_code = 3'd1; pin_en = 2'b00; pins(2'b11);
    ticks(6);
    drained("R3");
    pin_en = 2'b01; pins(2'b10);
    ticks(6);
    drained("R3");
    pins(2'b00);

    // R1 and R4: each code on pin 0, no clear
    clr_en = 1'b0; pin_en = 2'b01;
    for (int k = 1; k < 8; k++) begin
      cur_req = "R1";
      period_code = 3'(k); idle(4);
      pins(2'b01);
      ticks(k);
      drained("R1");
      expect_item(3'b001, "R1");
      ticks(1);
      drained("R1");
      cur_req = "R4";
      ticks(3);
      drained("R4");
      pins(2'b00);
    end

    // R4: rearm after going inactive
    cur_req = "R4";
    period_code = 3'd1; idle(4);
    pins(2'b01);
    ticks(1);
    drained("R4");
    expect_item(3'b001, "R4");
    ticks(1);
    drained("R4");
    pins(2'b00);

    // R5: brief drop loses the count
    cur_req = "R5";
    period_code = 3'd4; idle(4);
    pins(2'b01);
    ticks(3);
    wake_pin = 2'b00; idle(2);
    pins(2'b01);
    ticks(4);
    drained("R5");
    expect_item(3'b001, "R5");
    ticks(1);
    drained("R5");
    pins(2'b00);

    // R6: code change discards counts
    cur_req = "R6";
    period_code = 3'd3; idle(4);
    pins(2'b01);
    ticks(3);
    period_code = 3'd2; idle(4);
    ticks(2);
    drained("R6");
    expect_item(3'b001, "R6");
    ticks(1);
    drained("R6");
    pins(2'b00);

    // R7: simultaneous qualification gives one clear pulse
    cur_req = "R7";
    pin_en = 2'b11; clr_en = 1'b1; idle(4);
    pins(2'b11);
    ticks(2);
    drained("R7");
    expect_item(3'b111, "R7");
    ticks(1);
    drained("R7");
    pins(2'b00);
    pins(2'b10);
    ticks(2);
    drained("R7");
    expect_item(3'b110, "R7");
    ticks(1);
    drained("R7");
    pins(2'b00);

    // R9: long tick counts once
    cur_req = "R9";
    clr_en = 1'b0; period_code = 3'd1; idle(4);
    pins(2'b10);
    ticks(1, 40);
    drained("R9");
    expect_item(3'b010, "R9");
    ticks(1);
    drained("R9");
    pins(2'b00);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run hung actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule